// File: doc/BRIEF.md
# Deflection Router Input Side-Buffer Stage

This block is the input stage of a five-direction deflection router that keeps a very small amount of storage. Each input direction owns a single-entry side buffer. A packet that the external scheduler grants leaves in the same cycle toward the crossbar. A packet whose destination port is busy is parked in its direction's side buffer when the scheduler asks for that. A parked packet leaves later, when that direction is granted again.

The scheduler drives two signals per direction: a grant and a store request. When a side buffer is occupied, the grant always releases the parked packet. That packet therefore leaves before any newer packet from the same direction. A re-injection and a new store can share one clock edge. Across the whole stage, at most one packet per cycle is moved into side storage. If a store cannot be honoured, the stage raises a per-direction overflow flag instead. The scheduler, the crossbar, route computation and the links are outside this block.

Top module: `defl_input_stage`

## Requirements
- R1: A packet is 22 bits: data in bits [21:6], source address in [5:3], destination address in [2:0]. A packet leaves the block with every field unchanged.
- R2: A synchronous active-high reset empties every side buffer. After reset, a direction with no grant drives out_valid low.
- R3: When a direction's buffer is empty and it has grant with in_valid, out_pkt equals in_pkt in the same cycle, with out_valid high and out_reinj low. The buffer is not written, even if store is also high.
- R4: When the buffer is empty, grant is low, and in_valid and store are high (and the store is selected, see R8), the packet is held from the next edge onward. The output stays invalid until a grant.
- R5: When the buffer is occupied and grant is high, the held packet is driven with out_valid and out_reinj high, and the buffer empties at the edge.
- R6: When the buffer is occupied and granted while a new packet also asks to be stored, the held packet leaves first. The new packet is stored at the same edge.
- R7: A store request on an occupied buffer without grant is refused. The overflow flag rises, and the held packet is not overwritten.
- R8: At most one packet per cycle enters side storage across all directions. Among eligible store requests, the lowest direction index wins. The others raise overflow.
- R9: in_valid without grant and without store has no effect: no output and no buffer change. An occupied, ungranted buffer drives no output.
- R10: overflow is high exactly when a direction requests a store that is not taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Per-direction incoming packet valid |
| in_pkt | input | 110 | Incoming packets, direction d at bits [22d+21:22d] |
| grant | input | 5 | Per-direction scheduler grant |
| store | input | 5 | Per-direction request to park the incoming packet |
| out_valid | output | 5 | Per-direction output packet valid |
| out_pkt | output | 110 | Outgoing packets, same packing as in_pkt |
| out_reinj | output | 5 | Output carries a re-injected (previously parked) packet |
| overflow | output | 5 | A store request in this direction was refused this cycle |

## Verification
Assertions in the RTL are checked on every cycle. They cover the following:
- A parked packet stays intact while its direction is not granted.
- A refused store never disturbs the stored word.
- A re-injection only comes from an occupied buffer.
- A re-inject-and-store edge leaves the buffer full.
- No more than one direction is accepted into storage in any cycle.

Other behaviours need the bench's scenarios. These are the exact data moved on pass-through and re-injection, the field layout, lowest-index selection among competing stores, and the fact that an unrequested packet disappears without trace. The bench checks them by comparing against a cycle model over directed and random traffic.

// File: rtl/defl_pkg.sv
package defl_pkg;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 3;
    localparam int PKT_W     = DATA_W + 2 * ADDR_W;
    localparam int NUM_PORTS = 5;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
    } pkt_t;

    typedef struct packed {
        logic valid;
        logic reinj;
        pkt_t pkt;
    } lane_out_t;

    function automatic pkt_t pick_pkt(input logic from_buf, input pkt_t held, input pkt_t incoming);
        return from_buf ? held : incoming;
    endfunction
endpackage

// File: rtl/defl_store_pick.sv
module defl_store_pick #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cand,
    output logic [N-1:0] accept
);
    always_comb begin
        logic found;
        found  = 1'b0;
        accept = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && !found) begin
                accept[i] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    // R8: at most one store per cycle, only among candidates
    a_r8_single_store: assert property (@(posedge clk) disable iff (rst)
        $onehot0(accept) && ((accept & ~cand) == '0));
endmodule

// File: rtl/defl_side_lane.sv
module defl_side_lane
    import defl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  pkt_t      in_pkt,
    input  logic      grant,
    input  logic      store,
    input  logic      store_accept,
    output logic      store_cand,
    output lane_out_t lane_out,
    output logic      overflow
);
    logic occ_q;
    pkt_t held_q;
    logic pass_thru;
    logic store_req;
    logic room;

    assign pass_thru  = !occ_q && grant && in_valid;
    assign store_req  = in_valid && store && !pass_thru;
    assign room       = !occ_q || grant;
    assign store_cand = store_req && room;
    assign overflow   = store_req && !store_accept;

    always_comb begin
        lane_out.valid = grant && (occ_q || in_valid);
        lane_out.reinj = grant && occ_q;
        lane_out.pkt   = pick_pkt(occ_q, held_q, in_pkt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q  <= 1'b0;
            held_q <= '0;
        end else if (store_accept) begin
            occ_q  <= 1'b1;
            held_q <= in_pkt;
        end else if (occ_q && grant) begin
            occ_q  <= 1'b0;
        end
    end

    a_r2_reset_empty: assert property (@(posedge clk)
        rst |=> !occ_q);

    a_r7_hold_parked: assert property (@(posedge clk) disable iff (rst)
        (occ_q && !grant) |=> (occ_q && $stable(held_q)));

    a_r10_refused_no_write: assert property (@(posedge clk) disable iff (rst)
        overflow |=> $stable(held_q));

    a_r5_reinj_from_buffer: assert property (@(posedge clk) disable iff (rst)
        lane_out.reinj |-> (lane_out.valid && occ_q));

    a_r6_reinject_then_store: assert property (@(posedge clk) disable iff (rst)
        (occ_q && grant && store_accept) |=> occ_q);
endmodule

// File: rtl/defl_input_stage.sv
module defl_input_stage
    import defl_pkg::*;
#(
    parameter int NUM_DIR = NUM_PORTS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_DIR-1:0]       in_valid,
    input  logic [NUM_DIR*PKT_W-1:0] in_pkt,
    input  logic [NUM_DIR-1:0]       grant,
    input  logic [NUM_DIR-1:0]       store,
    output logic [NUM_DIR-1:0]       out_valid,
    output logic [NUM_DIR*PKT_W-1:0] out_pkt,
    output logic [NUM_DIR-1:0]       out_reinj,
    output logic [NUM_DIR-1:0]       overflow
);
    logic [NUM_DIR-1:0] cand;
    logic [NUM_DIR-1:0] accept;

    defl_store_pick #(.N(NUM_DIR)) u_pick (
        .clk    (clk),
        .rst    (rst),
        .cand   (cand),
        .accept (accept)
    );

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_lane
        lane_out_t lo;

        defl_side_lane u_lane (
            .clk          (clk),
            .rst          (rst),
            .in_valid     (in_valid[d]),
            .in_pkt       (pkt_t'(in_pkt[d*PKT_W +: PKT_W])),
            .grant        (grant[d]),
            .store        (store[d]),
            .store_accept (accept[d]),
            .store_cand   (cand[d]),
            .lane_out     (lo),
            .overflow     (overflow[d])
        );

        assign out_valid[d]               = lo.valid;
        assign out_reinj[d]               = lo.reinj;
        assign out_pkt[d*PKT_W +: PKT_W]  = lo.pkt;
    end
endmodule

// File: tb/defl_input_stage_bench.sv
`timescale 1ns/1ps
module defl_input_stage_bench;
    localparam int N = 5;
    localparam int W = 22;

    logic           clk = 1'b0;
    logic           rst;
    logic [N-1:0]   in_valid, grant, store;
    logic [N*W-1:0] in_pkt;
    logic [N-1:0]   out_valid, out_reinj, overflow;
    logic [N*W-1:0] out_pkt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic         m_occ [N];
    logic [W-1:0] m_buf [N];

    always #2 clk = ~clk;

    defl_input_stage u_defl_input_stage (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pkt(in_pkt),
        .grant(grant), .store(store), .out_valid(out_valid),
        .out_pkt(out_pkt), .out_reinj(out_reinj), .overflow(overflow)
    );

    function automatic logic [W-1:0] mk(input logic [15:0] d, input logic [2:0] s, input logic [2:0] t);
        return {d, s, t};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // evaluate one cycle: inputs already driven; check at negedge, update model after posedge
    task automatic cycle();
        logic [N-1:0] req, cand, acc;
        bit found;
        @(negedge clk);
        found = 0;
        for (int i = 0; i < N; i++) begin
            req[i]  = in_valid[i] && store[i] && !(!m_occ[i] && grant[i] && in_valid[i]);
            cand[i] = req[i] && (!m_occ[i] || grant[i]);
            acc[i]  = cand[i] && !found;
            if (cand[i]) found = 1;
        end
        for (int i = 0; i < N; i++) begin
            logic ev, er;
            logic [W-1:0] ep;
            string tag;
            ev = grant[i] && (m_occ[i] || in_valid[i]);
            er = grant[i] && m_occ[i];
            ep = m_occ[i] ? m_buf[i] : in_pkt[i*W +: W];
            if (er && acc[i])                          tag = "R6";
            else if (er)                               tag = "R5";
            else if (!m_occ[i] && grant[i] && in_valid[i]) tag = "R3";
            else if (acc[i])                           tag = "R4";
            else if (req[i] && m_occ[i] && !grant[i])  tag = "R7";
            else if (req[i])                           tag = "R8";
            else                                       tag = "R9";
            chk(out_valid[i] == ev && out_reinj[i] == er, $sformatf("%s dir%0d valid/reinj", tag, i),
                W'({out_valid[i], out_reinj[i]}), W'({ev, er}));
            if (ev) chk(out_pkt[i*W +: W] == ep, $sformatf("%s dir%0d pkt", tag, i), out_pkt[i*W +: W], ep);
            chk(overflow[i] == (req[i] && !acc[i]), $sformatf("R10 dir%0d overflow", i),
                W'(overflow[i]), W'(req[i] && !acc[i]));
        end
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (acc[i]) begin
                m_occ[i] = 1'b1;
                m_buf[i] = in_pkt[i*W +: W];
            end else if (m_occ[i] && grant[i]) begin
                m_occ[i] = 1'b0;
            end
        end
        #1;
    endtask

    task automatic drive(input logic [N-1:0] v, input logic [N-1:0] g, input logic [N-1:0] s);
        in_valid = v; grant = g; store = s;
        for (int i = 0; i < N; i++)
            in_pkt[i*W +: W] = mk(16'(32'hA000 + i * 17 + checks), 3'(i), 3'(4 - i));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; in_valid = '0; grant = '0; store = '0; in_pkt = '0;
        for (int i = 0; i < N; i++) begin m_occ[i] = 1'b0; m_buf[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R2: after reset, no grant means no output and buffers empty
        drive('0, '0, '0);
        @(negedge clk);
        chk(out_valid == '0 && overflow == '0, "R2 reset outputs", W'({out_valid, overflow}), '0);
        @(posedge clk); #1;
        // R1: field positions preserved on pass-through
        drive(5'b00001, 5'b00001, 5'b00001);
        in_pkt[W-1:0] = mk(16'hBEEF, 3'd5, 3'd2);
        @(negedge clk);
        chk(out_pkt[21:6] == 16'hBEEF && out_pkt[5:3] == 3'd5 && out_pkt[2:0] == 3'd2,
            "R1 field layout", out_pkt[W-1:0], mk(16'hBEEF, 3'd5, 3'd2));
        @(posedge clk); #1;
        // R4 store, R9 idle, R7 refused store, R6 reinject+store, R5 reinject
        drive(5'b00010, '0, 5'b00010); cycle();
        drive(5'b00010, '0, '0);       cycle();
        drive(5'b00010, '0, 5'b00010); cycle();
        drive(5'b00010, 5'b00010, 5'b00010); cycle();
        drive('0, 5'b00010, '0);       cycle();
        // R8: all directions request a store at once
        drive(5'b11111, '0, 5'b11111); cycle();
        drive('0, 5'b11111, '0);       cycle();
        // random traffic
        for (int c = 0; c < 3000; c++) begin
            in_valid = N'($urandom);
            grant    = N'($urandom) & N'($urandom);
            store    = N'($urandom);
            for (int i = 0; i < N; i++) in_pkt[i*W +: W] = W'($urandom);
            cycle();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule